// File: doc/BRIEF.md
# Triple-Redundant Voted Counter

This block keeps a free-running binary count in three identical registers that advance in lockstep. A per-bit two-out-of-three majority vote forms the single count the rest of the chip sees, so an upset confined to one copy never reaches the output. Each copy computes its next value from the voted count rather than from its own contents. A damaged copy is therefore overwritten with the correct value on the next enabled clock, and the upset is both hidden and repaired.

Two diagnostic outputs go with the count. A disagreement flag is high whenever the three registers do not all hold the same value. A two-bit code names the one copy that stands apart, when there is exactly one. A fault-injection port lets a test flip any set of bits in any single copy at a chosen clock edge, so the masking and repair paths can be exercised on demand.

Top module: `tmr_counter`

## Requirements
- R1: With `en` high and no injection, the voted `count` rises by one at every clock edge and wraps from 2^WIDTH-1 to 0.
- R2: With `en` low and no injection, every copy keeps its value, so `count` does not change.
- R3: XOR-ing any mask into any one copy leaves `count` equal to the value the fault-free counter would show.
- R4: `mismatch` is high exactly when the three copy registers are not all equal.
- R5: `odd_copy` is 1, 2 or 3 when only copy 0, 1 or 2 differs from the other two, which are equal. It is 0 when all copies agree or when no two copies are equal.
- R6: At an enabled edge without injection, every copy loads the voted count plus one, so `mismatch` is low afterwards.
- R7: While `en` is low, a corrupted copy keeps its corrupted value and `mismatch` stays high.
- R8: When `inj_valid` is high at an edge, `inj_mask` is XOR-ed into the value loaded by the copy that `inj_sel` picks (1, 2 or 3 for copy 0, 1 or 2). With `inj_sel` = 0 the injection has no effect.
- R9: If the same bit is flipped in two different copies before a repair, the vote is defeated and `count` shows that bit flipped.
- R10: Synchronous reset sets all three copies to zero, and it takes priority over `en` and over injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| inj_valid | input | 1 | Apply the injection mask at this edge |
| inj_sel | input | 2 | Target copy: 1, 2 or 3 for copy 0, 1 or 2; 0 selects none |
| inj_mask | input | WIDTH | Bits to flip in the target copy |
| count | output | WIDTH | Majority-voted count |
| mismatch | output | 1 | High when the copies are not all equal |
| odd_copy | output | 2 | Code of the single disagreeing copy, 0 if none |

## Verification
On every cycle the assertions check several properties: increment and hold of the voted count, that a single injection into agreeing copies leaves `count` unchanged, that an enabled edge without injection clears the disagreement, and that the copy code agrees with the flag. Some behaviours only the directed scenarios can show. These are the reset value, the wrap at full scale, the ignored selector value 0, the persistence of damage while disabled, the zero code for a two-copy scattered fault, and the defeated vote after a same-bit double hit.

// File: rtl/tmrc_pkg.sv
package tmrc_pkg;
    localparam int unsigned NUM_COPIES = 3;

    typedef enum logic [1:0] {
        ODD_NONE  = 2'd0,
        ODD_COPY0 = 2'd1,
        ODD_COPY1 = 2'd2,
        ODD_COPY2 = 2'd3
    } odd_code_e;
endpackage

// File: rtl/tmrc_replica.sv
module tmrc_replica #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] voted,
    input  logic [WIDTH-1:0] flip,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } rep_state_t;

    rep_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en) begin
            state_d.cnt = voted + STEP;
        end
        state_d.cnt = state_d.cnt ^ flip;
        if (rst) begin
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign value = state_q.cnt;
endmodule

// File: rtl/tmrc_voter.sv
module tmrc_voter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] copy_a,
    input  logic [WIDTH-1:0] copy_b,
    input  logic [WIDTH-1:0] copy_c,
    output logic [WIDTH-1:0] voted,
    output logic             disagree,
    output logic [1:0]       odd_code
);
    import tmrc_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] maj;
        logic             eq_ab;
        logic             eq_bc;
        logic             eq_ac;
        odd_code_e        odd;
    } vote_t;

    vote_t vote_d;

    always_comb begin
        vote_d.maj   = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);
        vote_d.eq_ab = (copy_a == copy_b);
        vote_d.eq_bc = (copy_b == copy_c);
        vote_d.eq_ac = (copy_a == copy_c);
        if (vote_d.eq_bc && !vote_d.eq_ab) begin
            vote_d.odd = ODD_COPY0;
        end else if (vote_d.eq_ac && !vote_d.eq_ab) begin
            vote_d.odd = ODD_COPY1;
        end else if (vote_d.eq_ab && !vote_d.eq_bc) begin
            vote_d.odd = ODD_COPY2;
        end else begin
            vote_d.odd = ODD_NONE;
        end
    end

    assign voted    = vote_d.maj;
    assign disagree = !(vote_d.eq_ab && vote_d.eq_bc);
    assign odd_code = vote_d.odd;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inj_valid,
    input  logic [1:0]       inj_sel,
    input  logic [WIDTH-1:0] inj_mask,
    output logic [WIDTH-1:0] count,
    output logic             mismatch,
    output logic [1:0]       odd_copy
);
    import tmrc_pkg::*;

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [NUM_COPIES-1:0][WIDTH-1:0] copy_q;
    logic [NUM_COPIES-1:0][WIDTH-1:0] flip_d;
    logic [WIDTH-1:0]                 voted;

    for (genvar gi = 0; gi < NUM_COPIES; gi++) begin : g_copy
        always_comb begin
            flip_d[gi] = '0;
            if (inj_valid && (inj_sel == 2'(gi + 1))) begin
                flip_d[gi] = inj_mask;
            end
        end

        tmrc_replica #(.WIDTH(WIDTH)) u_rep (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .voted (voted),
            .flip  (flip_d[gi]),
            .value (copy_q[gi])
        );
    end

    tmrc_voter #(.WIDTH(WIDTH)) u_vote (
        .copy_a   (copy_q[0]),
        .copy_b   (copy_q[1]),
        .copy_c   (copy_q[2]),
        .voted    (voted),
        .disagree (mismatch),
        .odd_code (odd_copy)
    );

    assign count = voted;

    // R1: a clean enabled edge advances the voted count by one
    a_r1_increment: assert property (@(posedge clk) disable iff (rst)
        (en && !inj_valid && !mismatch) |=> (count == $past(count) + STEP));

    // R2: a clean disabled edge leaves the voted count alone
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !inj_valid) |=> $stable(count));

    // R3: one injection into agreeing copies is masked at the output
    a_r3_single_masked: assert property (@(posedge clk) disable iff (rst)
        (!en && inj_valid && !mismatch) |=> $stable(count));

    // R6: an enabled edge without injection resynchronises all copies
    a_r6_repair: assert property (@(posedge clk) disable iff (rst)
        (en && !inj_valid) |=> !mismatch);

    // R5: an identified copy implies disagreement
    a_r5_code_flag: assert property (@(posedge clk) disable iff (rst)
        (odd_copy != 2'd0) |-> mismatch);
endmodule

// File: tb/sim_tmr_counter.sv
module sim_tmr_counter;
    localparam int unsigned WIDTH = 8;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             inj_valid = 1'b0;
    logic [1:0]       inj_sel = 2'd0;
    logic [WIDTH-1:0] inj_mask = '0;
    logic [WIDTH-1:0] count;
    logic             mismatch;
    logic [1:0]       odd_copy;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] exp_cnt = '0;

    always #4 clk = ~clk;

    tmr_counter #(.WIDTH(WIDTH)) u0 (
        .clk(clk), .rst(rst), .en(en), .inj_valid(inj_valid),
        .inj_sel(inj_sel), .inj_mask(inj_mask),
        .count(count), .mismatch(mismatch), .odd_copy(odd_copy)
    );

    task automatic tick(input logic e, input logic iv, input logic [1:0] s,
                        input logic [WIDTH-1:0] m);
        en = e; inj_valid = iv; inj_sel = s; inj_mask = m;
        @(posedge clk);
        #2;
        en = 1'b0; inj_valid = 1'b0; inj_sel = 2'd0; inj_mask = '0;
    endtask

    task automatic check(input string req, input logic [WIDTH-1:0] c,
                         input logic mm, input logic [1:0] oc);
        checks++;
        if (count !== c || mismatch !== mm || odd_copy !== oc) begin
            errors++;
            $display("FAIL %s: count=%0d mismatch=%0b odd=%0d expected count=%0d mismatch=%0b odd=%0d",
                     req, count, mismatch, odd_copy, c, mm, oc);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(1'b1, 1'b1, 2'd2, 8'hFF);
        rst = 1'b0;
        exp_cnt = '0;
        check("R10 reset clears and overrides injection", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_count;
        for (int k = 0; k < 5; k++) begin
            tick(1'b1, 1'b0, 2'd0, '0);
            exp_cnt = exp_cnt + ONE;
        end
        check("R1 counting", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_hold;
        tick(1'b0, 1'b0, 2'd0, '0);
        tick(1'b0, 1'b0, 2'd0, '0);
        check("R2 hold while disabled", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_sel_zero;
        tick(1'b0, 1'b1, 2'd0, 8'hFF);
        check("R8 selector 0 ignored", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_single(input logic [1:0] sel, input logic [WIDTH-1:0] m);
        tick(1'b1, 1'b1, sel, m);
        exp_cnt = exp_cnt + ONE;
        check("R3 R8 single fault masked and located", exp_cnt, 1'b1, sel);
        tick(1'b0, 1'b0, 2'd0, '0);
        check("R7 fault persists while disabled", exp_cnt, 1'b1, sel);
        tick(1'b1, 1'b0, 2'd0, '0);
        exp_cnt = exp_cnt + ONE;
        check("R6 repair on enabled edge", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_scatter;
        tick(1'b0, 1'b1, 2'd1, 8'h01);
        tick(1'b0, 1'b1, 2'd2, 8'h08);
        check("R5 R4 two copies differ in different bits", exp_cnt, 1'b1, 2'd0);
        tick(1'b1, 1'b0, 2'd0, '0);
        exp_cnt = exp_cnt + ONE;
        check("R6 repair after scattered fault", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_same_copy_twice;
        tick(1'b0, 1'b1, 2'd3, 8'h10);
        tick(1'b0, 1'b1, 2'd3, 8'h20);
        check("R3 repeated hits on one copy masked", exp_cnt, 1'b1, 2'd3);
        tick(1'b1, 1'b0, 2'd0, '0);
        exp_cnt = exp_cnt + ONE;
        check("R6 repair after repeated hits", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_double;
        tick(1'b0, 1'b1, 2'd2, 8'h04);
        tick(1'b0, 1'b1, 2'd3, 8'h04);
        exp_cnt = exp_cnt ^ 8'h04;
        check("R9 same-bit double hit defeats vote", exp_cnt, 1'b1, 2'd1);
        tick(1'b1, 1'b0, 2'd0, '0);
        exp_cnt = exp_cnt + ONE;
        check("R6 copies rejoin on wrong value", exp_cnt, 1'b0, 2'd0);
    endtask

    task automatic t_wrap;
        while (exp_cnt != {WIDTH{1'b1}}) begin
            tick(1'b1, 1'b0, 2'd0, '0);
            exp_cnt = exp_cnt + ONE;
        end
        check("R1 at full scale", exp_cnt, 1'b0, 2'd0);
        tick(1'b1, 1'b0, 2'd0, '0);
        exp_cnt = '0;
        check("R1 wrap to zero", exp_cnt, 1'b0, 2'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2;
        t_reset;
        t_count;
        t_hold;
        t_sel_zero;
        t_single(2'd1, 8'hFF);
        t_single(2'd2, 8'h01);
        t_single(2'd3, 8'h80);
        t_scatter;
        t_same_copy_twice;
        t_double;
        t_wrap;
        t_reset;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule